// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Pin Sharing

This block is an eight-pin general-purpose I/O port. It sits behind a small register bus with address, write strobe, write data, read strobe and read data. Each pin has its own direction bit and its own output data bit. The pin levels are brought into the clock domain through a synchronizer before they reach the bus or the peripheral.

The direction register can only be written. Its address is shared with the pin-level view, so a read there returns the synchronized pad levels. A peripheral-select input hands the upper pins (7 down to 2 by default) to a peripheral, which then supplies their output enables and output values. The two lowest pins stay under register control at all times.

Pad drivers get a per-pin output value and an active-high output enable. A pin with its enable low is high-impedance.

Top module: `gpio_port`

## Requirements
- R1: After reset every direction bit and every output data bit is 0, so `pad_oe_o` is 0x00 while `alt_en_i` is 0 and a read of the output data register returns 0x00.
- R2: With `alt_en_i` low, a write to address 0 sets the direction bits, and `pad_oe_o[i]` equals bit i of the written value from the clock edge that accepts the write. A 1 makes the pin an output and a 0 makes it an input.
- R3: A write to address 1 stores the output data bits, and `pad_out_o` shows them from the clock edge that accepts the write, for every pin under register control.
- R4: A read at address 0 returns the pad levels through a two-flop synchronizer. The returned value is the `pad_in_i` level sampled two clock edges earlier, never the stored direction bits. `per_in_o` carries the same synchronized levels for the upper pins.
- R5: The output data register at address 1 reads back its last written value whatever the direction bits are. A value written while a pin is an input appears on the pad once the pin is switched to output.
- R6: While `alt_en_i` is 1, `pad_oe_o` and `pad_out_o` for pins 7 down to 2 follow `per_oe_i` and `per_out_i` (peripheral bit 0 maps to pin 2), and the direction bits of those pins have no effect.
- R7: Pins 1 and 0 take their enable from the direction bits and their value from the output data bits, whatever the level of `alt_en_i`.
- R8: Addresses 2 and 3 are unmapped. A read there returns 0x00, and a write there changes neither the direction bits nor the output data bits.
- R9: `bus_rdata_o` is 0x00 in any cycle in which `bus_re_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register address: 0 = direction (write) / pin levels (read), 1 = output data |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | 8 | Read data, combinational while `bus_re_i` is high |
| pad_in_i | input | 8 | Levels seen at the pads |
| pad_out_o | output | 8 | Value for the pad drivers |
| pad_oe_o | output | 8 | Pad output enable, 1 = drive |
| alt_en_i | input | 1 | Hands the upper pins to the peripheral |
| per_out_i | input | 6 | Peripheral output values for pins 7..2 |
| per_oe_i | input | 6 | Peripheral output enables for pins 7..2 |
| per_in_o | output | 6 | Synchronized levels of pins 7..2 for the peripheral |

## Verification
A corrupted direction or output data bit appears on `pad_oe_o` or `pad_out_o` in the cycle after the write that set it, and a read of address 1 also exposes the output data bits. A fault in the synchronizer shows on pin-level reads as a value that lags by the wrong number of edges: an early read after a pad change would return the new level one edge too soon, or the read would stay on the old level past the second edge. An address-decode fault shows either as a nonzero read at an unmapped address or as a pad enable that changes after a write that should have been ignored.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned ADDR_W = 2;
    // Address 0 is shared: writes land in the direction bits, reads see pins.
    localparam logic [ADDR_W-1:0] ADR_DIR_PIN = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_ODR     = 2'd1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic              re_i,
    input  logic [WIDTH-1:0]  pin_sync_i,
    output logic [WIDTH-1:0]  rdata_o,
    output logic [WIDTH-1:0]  dir_o,
    output logic [WIDTH-1:0]  odr_o
);
    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] odr;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            case (addr_i)
                ADR_DIR_PIN: regs_d.dir = wdata_i;
                ADR_ODR:     regs_d.odr = wdata_i;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    // Direction bits are never visible on the read path.
    always_comb begin
        rdata_o = '0;
        if (re_i) begin
            case (addr_i)
                ADR_DIR_PIN: rdata_o = pin_sync_i;
                ADR_ODR:     rdata_o = regs_q.odr;
                default:     rdata_o = '0;
            endcase
        end
    end

    assign dir_o = regs_q.dir;
    assign odr_o = regs_q.odr;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int unsigned WIDTH   = 8,
    parameter int unsigned ALT_LSB = 2,
    localparam int unsigned ALT_W  = WIDTH - ALT_LSB
) (
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] odr_i,
    input  logic             alt_en_i,
    input  logic [ALT_W-1:0] per_out_i,
    input  logic [ALT_W-1:0] per_oe_i,
    output logic [WIDTH-1:0] pad_out_o,
    output logic [WIDTH-1:0] pad_oe_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (i >= ALT_LSB) begin : g_shared
            assign pad_oe_o[i]  = alt_en_i ? per_oe_i[i-ALT_LSB]  : dir_i[i];
            assign pad_out_o[i] = alt_en_i ? per_out_i[i-ALT_LSB] : odr_i[i];
        end else begin : g_own
            assign pad_oe_o[i]  = dir_i[i];
            assign pad_out_o[i] = odr_i[i];
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned ALT_LSB     = 2,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned ALT_W      = WIDTH - ALT_LSB
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [WIDTH-1:0]  bus_wdata_i,
    input  logic              bus_re_i,
    output logic [WIDTH-1:0]  bus_rdata_o,
    input  logic [WIDTH-1:0]  pad_in_i,
    output logic [WIDTH-1:0]  pad_out_o,
    output logic [WIDTH-1:0]  pad_oe_o,
    input  logic              alt_en_i,
    input  logic [ALT_W-1:0]  per_out_i,
    input  logic [ALT_W-1:0]  per_oe_i,
    output logic [ALT_W-1:0]  per_in_o
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] odr_q;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pad_in_i),
        .sync_o  (pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) regs_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .addr_i     (bus_addr_i),
        .we_i       (bus_we_i),
        .wdata_i    (bus_wdata_i),
        .re_i       (bus_re_i),
        .pin_sync_i (pin_sync),
        .rdata_o    (bus_rdata_o),
        .dir_o      (dir_q),
        .odr_o      (odr_q)
    );

    gpio_pad_mux #(.WIDTH(WIDTH), .ALT_LSB(ALT_LSB)) mux_i (
        .dir_i     (dir_q),
        .odr_i     (odr_q),
        .alt_en_i  (alt_en_i),
        .per_out_i (per_out_i),
        .per_oe_i  (per_oe_i),
        .pad_out_o (pad_out_o),
        .pad_oe_o  (pad_oe_o)
    );

    assign per_in_o = pin_sync[WIDTH-1:ALT_LSB];
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned ALT_LSB     = 2,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned ALT_W      = WIDTH - ALT_LSB
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic [WIDTH-1:0]  bus_wdata_i,
    input logic              bus_re_i,
    input logic [WIDTH-1:0]  bus_rdata_o,
    input logic [WIDTH-1:0]  pad_in_i,
    input logic [WIDTH-1:0]  pad_out_o,
    input logic [WIDTH-1:0]  pad_oe_o,
    input logic              alt_en_i,
    input logic [ALT_W-1:0]  per_out_i,
    input logic [ALT_W-1:0]  per_oe_i,
    input logic [ALT_W-1:0]  per_in_o
);
    // Edges seen since reset released, saturating at 3.
    logic [1:0] cyc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    logic odr_wr, odr_rd;
    assign odr_wr = bus_we_i && (bus_addr_i == ADR_ODR);
    assign odr_rd = bus_re_i && (bus_addr_i == ADR_ODR);

    a_r1_reset_low_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (pad_oe_o[ALT_LSB-1:0] == '0));

    a_r3_odr_to_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
        odr_wr |=> (pad_out_o[ALT_LSB-1:0] == $past(bus_wdata_i[ALT_LSB-1:0])));

    a_r2_dir_to_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == ADR_DIR_PIN) |=>
            (pad_oe_o[ALT_LSB-1:0] == $past(bus_wdata_i[ALT_LSB-1:0])));

    a_r4_pin_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (SYNC_STAGES == 2 && cyc_q >= 2'd2 && bus_re_i && bus_addr_i == ADR_DIR_PIN)
            |-> (bus_rdata_o == $past(pad_in_i, 2)));

    a_r4_per_in_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (SYNC_STAGES == 2 && cyc_q >= 2'd2)
            |-> (per_in_o == $past(pad_in_i[WIDTH-1:ALT_LSB], 2)));

    a_r5_odr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_q >= 2'd1 && odr_rd && $past(odr_rd) && !$past(odr_wr)) |-> $stable(bus_rdata_o));

    a_r6_peripheral_owns: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alt_en_i |-> (pad_oe_o[WIDTH-1:ALT_LSB] == per_oe_i &&
                      pad_out_o[WIDTH-1:ALT_LSB] == per_out_i));

    a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_re_i && bus_addr_i != ADR_DIR_PIN && bus_addr_i != ADR_ODR) |-> (bus_rdata_o == '0));

    a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_re_i |-> (bus_rdata_o == '0));
endmodule

bind gpio_port gpio_port_chk #(
    .WIDTH(WIDTH), .ALT_LSB(ALT_LSB), .SYNC_STAGES(SYNC_STAGES)
) chk_i (.*);

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic       re = 1'b0;
    logic [7:0] rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic       alt_en = 1'b0;
    logic [5:0] per_out = '0;
    logic [5:0] per_oe = '0;
    logic [5:0] per_in;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gpio_port dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
        .bus_re_i(re), .bus_rdata_o(rdata),
        .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
        .alt_en_i(alt_en), .per_out_i(per_out), .per_oe_i(per_oe), .per_in_o(per_in)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; re = 1'b1;
        #1;
        d = rdata;
        re = 1'b0;
        #1;
    endtask

    initial begin : watchdog
        #3000000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        logic [7:0] v;
        logic [7:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 oe", pad_oe, 8'h00);
        check("R1 out", pad_out, 8'h00);
        rd(2'd1, v); check("R1 odr read", v, 8'h00);

        // R9: idle read data
        check("R9 idle", rdata, 8'h00);

        // R2: direction sweep
        for (int k = 0; k < 256; k++) begin
            wr(2'd0, 8'(k));
            check("R2 dir->oe", pad_oe, 8'(k));
            check("R9 idle after write", rdata, 8'h00);
        end

        // R3 / R5: output data sweep with all pins driving
        wr(2'd0, 8'hFF);
        for (int k = 0; k < 256; k++) begin
            wr(2'd1, 8'(k ^ 8'h5A));
            check("R3 odr->pad", pad_out, 8'(k ^ 8'h5A));
            rd(2'd1, v); check("R5 odr readback", v, 8'(k ^ 8'h5A));
        end

        // R5: value written while input is kept until output mode
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hA5);
        check("R5 oe stays off", pad_oe, 8'h00);
        rd(2'd1, v); check("R5 readback while input", v, 8'hA5);
        wr(2'd0, 8'hFF);
        check("R5 appears when output", pad_out, 8'hA5);
        check("R5 oe on", pad_oe, 8'hFF);

        // R4: pin read through two flops, never the direction bits
        wr(2'd0, 8'h3C);
        prev = pad_in;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 256; k++) begin
            pad_in = 8'(k * 37 + 11);
            @(negedge clk);
            rd(2'd0, v); check("R4 one edge still old", v, prev);
            @(negedge clk);
            rd(2'd0, v); check("R4 pin level", v, pad_in);
            check("R4 per_in", {2'b00, per_in}, {2'b00, pad_in[7:2]});
            prev = pad_in;
        end

        // R6 / R7: peripheral owns the upper pins
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        alt_en = 1'b1;
        for (int lo = 0; lo < 4; lo++) begin
            wr(2'd0, 8'(lo) | 8'hFC);
            wr(2'd1, 8'(3 - lo) | 8'h00);
            for (int k = 0; k < 64; k++) begin
                @(negedge clk);
                per_oe = 6'(k); per_out = 6'(~k);
                #1;
                check("R6 oe upper", {2'b00, pad_oe[7:2]}, {2'b00, 6'(k)});
                check("R6 out upper", {2'b00, pad_out[7:2]}, {2'b00, 6'(~k)});
                check("R7 oe low", {6'd0, pad_oe[1:0]}, {6'd0, 2'(lo)});
                check("R7 out low", {6'd0, pad_out[1:0]}, {6'd0, 2'(3 - lo)});
            end
        end
        alt_en = 1'b0;
        @(negedge clk);
        check("R6 dir back in control", pad_oe, 8'hFF);
        check("R7 out low after alt", {6'd0, pad_out[1:0]}, 8'h00);

        // R8: unmapped addresses
        wr(2'd0, 8'h96);
        wr(2'd1, 8'h69);
        for (int a = 2; a < 4; a++) begin
            wr(2'(a), 8'hFF);
            wr(2'(a), 8'h00);
            check("R8 oe untouched", pad_oe, 8'h96);
            check("R8 out untouched", pad_out, 8'h69);
            rd(2'(a), v); check("R8 read zero", v, 8'h00);
            rd(2'd1, v); check("R8 odr untouched", v, 8'h69);
        end

        // R9: strobe low with every address
        for (int a = 0; a < 4; a++) begin
            addr = 2'(a); #1;
            check("R9 no strobe", rdata, 8'h00);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule